// File: doc/BRIEF.md
# Page Access Permission Gate

This block rules on a single memory access once the page it targets is known. Each cycle it can take one request. A request carries the processor privilege mode, a 4-bit instruction class code, a flag that says a string transfer has zero length, and the page's four permission bits: read and write for user mode, and read and write for supervisor mode. One clock later it returns exactly one verdict. The verdict is one of four: the access is permitted, it is suppressed with a data storage interrupt, it quietly becomes a no-op, or a privileged-instruction program interrupt applies. Alongside the verdict it raises a flag for a read violation or for a write violation.

The block is built around a two-state machine. `ST_IDLE` means no verdict is presented and every output is zero. `ST_HOLD` means the verdict captured from the previous cycle's request is presented. The transition *accept* (`req_valid` = 1) enters or stays in `ST_HOLD`. The transition *drain* (`req_valid` = 0) enters or stays in `ST_IDLE`. A synchronous reset forces `ST_IDLE` and clears the held verdict. A class decoder, a rights selector and a combinational verdict stage feed the state machine.

Top module: `mem_perm_gate`

## Requirements
- R1: A write-class access checks the user write bit when `user_mode` = 1 and the supervisor write bit when `user_mode` = 0. If that bit is 1, only `out_permit` is raised and neither violation flag is set.
- R2: A read-class access checks the user read bit when `user_mode` = 1 and the supervisor read bit when `user_mode` = 0. If that bit is 1, only `out_permit` is raised.
- R3: The class codes are: 0 plain load, 1 plain store, 2 string load, 3 string store, 4 block zero, 5 block invalidate, 6 cache store, 7 cache flush, 8 data touch, 9 data touch-for-store, 10 instruction-cache invalidate, 11 instruction touch. The write class is {1,3,4,5} and every other code is read class. `len_zero` has an effect only for codes 2 and 3.
- R4: When a write-class access fails its check, `out_wr_viol` is set. A string store with `len_zero` = 1 gives `out_nop`. Every other write-class failure gives `out_dsi`.
- R5: When a plain load, cache store, cache flush or instruction-cache invalidate fails its read check, the result is `out_dsi` with `out_rd_viol` set.
- R6: When a string load with `len_zero` = 1, a data touch, a data touch-for-store or an instruction touch fails its read check, the result is `out_nop` with `out_rd_viol` set.
- R7: A block invalidate with `user_mode` = 1 gives `out_prog`, whatever the permission bits are. Both violation flags stay 0 and `out_dsi` stays 0.
- R8: For each valid request exactly one of `out_permit`, `out_dsi`, `out_nop` and `out_prog` is 1. In a cycle that follows no valid request, all six outputs are 0.
- R9: The outputs change on the first rising edge after the request is sampled and hold until the next edge. A synchronous `rst` clears every output at that edge, even if a request is present.
- R10: Class codes 12 to 15 behave exactly like code 0, the plain load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present this cycle |
| user_mode | input | 1 | 1 = user mode, 0 = supervisor mode |
| op_class | input | 4 | Instruction class code (see R3) |
| len_zero | input | 1 | The string transfer length is zero |
| perm_ur | input | 1 | User read permission |
| perm_uw | input | 1 | User write permission |
| perm_sr | input | 1 | Supervisor read permission |
| perm_sw | input | 1 | Supervisor write permission |
| out_permit | output | 1 | The access may proceed |
| out_dsi | output | 1 | Suppress the access and raise a data storage interrupt |
| out_nop | output | 1 | Suppress the access quietly, with no interrupt |
| out_prog | output | 1 | Privileged-instruction program interrupt |
| out_rd_viol | output | 1 | A read permission violation was found |
| out_wr_viol | output | 1 | A write permission violation was found |

## Verification
The bench sweeps all 1024 combinations of mode, class code, zero-length flag and permission bits, and places idle cycles between requests. The corner cases it targets are these. A zero-length string store or load that wrongly interrupts shows up as `out_dsi` where `out_nop` is expected. A touch hint that traps shows up the same way. A block invalidate in user mode that is routed through the write check shows up as a data storage interrupt or a write violation flag instead of `out_prog`. A rights selector that swaps the user and supervisor bits permits accesses in exactly those combinations where only the other mode's bit is set. Unused class codes that decode to something other than a plain load, and a verdict that lingers through an idle cycle or through reset, each produce output vectors that differ from the reference.

// File: rtl/mpg_pkg.sv
package mpg_pkg;

    localparam int CLASS_W = 4;

    typedef enum logic [CLASS_W-1:0] {
        OPC_LOAD      = 4'd0,
        OPC_STORE     = 4'd1,
        OPC_STR_LOAD  = 4'd2,
        OPC_STR_STORE = 4'd3,
        OPC_BLK_ZERO  = 4'd4,
        OPC_BLK_INVAL = 4'd5,
        OPC_CSTORE    = 4'd6,
        OPC_CFLUSH    = 4'd7,
        OPC_DTOUCH    = 4'd8,
        OPC_DTOUCH_ST = 4'd9,
        OPC_IINVAL    = 4'd10,
        OPC_ITOUCH    = 4'd11
    } op_class_e;

    // Properties of one instruction class, as the verdict stage needs them
    typedef struct packed {
        logic is_write;   // checked against a write permission bit
        logic is_priv;    // supervisor-only instruction
        logic is_hint;    // a failed check never interrupts
        logic is_string;  // the zero-length flag applies
    } op_attr_t;

    typedef struct packed {
        logic permit;
        logic dsi;
        logic nop;
        logic prog;
        logic rd_viol;
        logic wr_viol;
    } verdict_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1
    } gate_state_e;

endpackage

// File: rtl/mpg_class_decode.sv
module mpg_class_decode
    import mpg_pkg::*;
#(
    parameter int CW = CLASS_W
) (
    input  logic [CW-1:0] op_class,
    output op_attr_t      attr
);
    // R3 class membership; R10 codes 12..15 fall through to the plain-load default
    always_comb begin
        attr = '0;
        unique case (op_class)
            OPC_STORE:     attr.is_write = 1'b1;
            OPC_STR_STORE: begin
                attr.is_write  = 1'b1;
                attr.is_string = 1'b1;
            end
            OPC_BLK_ZERO:  attr.is_write = 1'b1;
            OPC_BLK_INVAL: begin
                attr.is_write = 1'b1;
                attr.is_priv  = 1'b1;
            end
            OPC_STR_LOAD:  attr.is_string = 1'b1;
            OPC_DTOUCH:    attr.is_hint = 1'b1;
            OPC_DTOUCH_ST: attr.is_hint = 1'b1;
            OPC_ITOUCH:    attr.is_hint = 1'b1;
            OPC_CSTORE, OPC_CFLUSH, OPC_IINVAL, OPC_LOAD: attr = '0;
            default:       attr = '0;
        endcase
    end
endmodule

// File: rtl/mpg_rights_select.sv
module mpg_rights_select (
    input  logic user_mode,
    input  logic perm_ur,
    input  logic perm_uw,
    input  logic perm_sr,
    input  logic perm_sw,
    output logic read_ok,
    output logic write_ok
);
    // R1 / R2: the mode picks which pair of permission bits applies
    always_comb begin
        if (user_mode) begin
            read_ok  = perm_ur;
            write_ok = perm_uw;
        end else begin
            read_ok  = perm_sr;
            write_ok = perm_sw;
        end
    end
endmodule

// File: rtl/mpg_verdict.sv
module mpg_verdict
    import mpg_pkg::*;
(
    input  op_attr_t attr,
    input  logic     user_mode,
    input  logic     len_zero,
    input  logic     read_ok,
    input  logic     write_ok,
    output verdict_t verdict
);
    logic quiet;

    // A failed check turns into a no-op for hints and for zero-length strings
    assign quiet = attr.is_hint | (attr.is_string & len_zero);

    always_comb begin
        verdict = '0;
        if (attr.is_priv && user_mode) begin
            // R7: the privilege trap comes before any permission check
            verdict.prog = 1'b1;
        end else if (attr.is_write) begin
            if (write_ok) begin
                verdict.permit = 1'b1;
            end else begin
                verdict.wr_viol = 1'b1;          // R4
                verdict.nop     = quiet;
                verdict.dsi     = ~quiet;
            end
        end else begin
            if (read_ok) begin
                verdict.permit = 1'b1;
            end else begin
                verdict.rd_viol = 1'b1;          // R5 / R6
                verdict.nop     = quiet;
                verdict.dsi     = ~quiet;
            end
        end
    end
endmodule

// File: rtl/mem_perm_gate.sv
module mem_perm_gate
    import mpg_pkg::*;
#(
    parameter int CW = CLASS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          user_mode,
    input  logic [CW-1:0] op_class,
    input  logic          len_zero,
    input  logic          perm_ur,
    input  logic          perm_uw,
    input  logic          perm_sr,
    input  logic          perm_sw,
    output logic          out_permit,
    output logic          out_dsi,
    output logic          out_nop,
    output logic          out_prog,
    output logic          out_rd_viol,
    output logic          out_wr_viol
);
    op_attr_t    attr;
    logic        read_ok;
    logic        write_ok;
    verdict_t    verdict_d;
    verdict_t    verdict_q;
    verdict_t    shown;
    gate_state_e state_q;
    gate_state_e state_d;

    mpg_class_decode #(.CW(CW)) u_decode (
        .op_class (op_class),
        .attr     (attr)
    );

    mpg_rights_select u_rights (
        .user_mode (user_mode),
        .perm_ur   (perm_ur),
        .perm_uw   (perm_uw),
        .perm_sr   (perm_sr),
        .perm_sw   (perm_sw),
        .read_ok   (read_ok),
        .write_ok  (write_ok)
    );

    mpg_verdict u_verdict (
        .attr      (attr),
        .user_mode (user_mode),
        .len_zero  (len_zero),
        .read_ok   (read_ok),
        .write_ok  (write_ok),
        .verdict   (verdict_d)
    );

    // Transitions: accept -> ST_HOLD, drain -> ST_IDLE
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = req_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and held verdict (R9)
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            verdict_q <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                verdict_q <= verdict_d;
            end
        end
    end

    // Outputs: only the hold state presents a verdict (R8)
    always_comb begin
        unique case (state_q)
            ST_HOLD: shown = verdict_q;
            ST_IDLE: shown = '0;
            default: shown = '0;
        endcase
    end

    assign out_permit  = shown.permit;
    assign out_dsi     = shown.dsi;
    assign out_nop     = shown.nop;
    assign out_prog    = shown.prog;
    assign out_rd_viol = shown.rd_viol;
    assign out_wr_viol = shown.wr_viol;

endmodule

// File: rtl/mem_perm_gate_chk.sv
module mem_perm_gate_chk #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          user_mode,
    input logic [CW-1:0] op_class,
    input logic          perm_uw,
    input logic          perm_sw,
    input logic          out_permit,
    input logic          out_dsi,
    input logic          out_nop,
    input logic          out_prog,
    input logic          out_rd_viol,
    input logic          out_wr_viol
);
    p_one_verdict_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> $countones({out_permit, out_dsi, out_nop, out_prog}) == 1);

    p_idle_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> {out_permit, out_dsi, out_nop, out_prog, out_rd_viol, out_wr_viol} == 6'b0);

    p_priv_trap_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && user_mode && op_class == CW'(5))
        |=> (out_prog && !out_wr_viol && !out_dsi));

    p_flags_apart_r4: assert property (@(posedge clk) disable iff (rst)
        !(out_rd_viol && out_wr_viol));

    p_permit_clean_r1: assert property (@(posedge clk) disable iff (rst)
        out_permit |-> (!out_rd_viol && !out_wr_viol));

    p_user_store_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && user_mode && op_class == CW'(1) && !perm_uw)
        |=> (out_dsi && out_wr_viol));

    p_super_store_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !user_mode && op_class == CW'(1) && perm_sw)
        |=> out_permit);
endmodule

bind mem_perm_gate mem_perm_gate_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .user_mode   (user_mode),
    .op_class    (op_class),
    .perm_uw     (perm_uw),
    .perm_sw     (perm_sw),
    .out_permit  (out_permit),
    .out_dsi     (out_dsi),
    .out_nop     (out_nop),
    .out_prog    (out_prog),
    .out_rd_viol (out_rd_viol),
    .out_wr_viol (out_wr_viol)
);

// File: tb/mem_perm_gate_tb.sv
module mem_perm_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       user_mode = 1'b0;
    logic [3:0] op_class = 4'd0;
    logic       len_zero = 1'b0;
    logic       perm_ur = 1'b0;
    logic       perm_uw = 1'b0;
    logic       perm_sr = 1'b0;
    logic       perm_sw = 1'b0;
    logic       out_permit, out_dsi, out_nop, out_prog, out_rd_viol, out_wr_viol;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_perm_gate u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .user_mode(user_mode),
        .op_class(op_class), .len_zero(len_zero),
        .perm_ur(perm_ur), .perm_uw(perm_uw), .perm_sr(perm_sr), .perm_sw(perm_sw),
        .out_permit(out_permit), .out_dsi(out_dsi), .out_nop(out_nop),
        .out_prog(out_prog), .out_rd_viol(out_rd_viol), .out_wr_viol(out_wr_viol)
    );

    // Reference, from the requirements. Vector order: permit,dsi,nop,prog,rd,wr
    function automatic logic [5:0] model(bit v, bit um, int cls, bit lz, bit [3:0] p);
        int  c;
        bit  writes, ok, silent;
        if (!v) return 6'b0;
        c = (cls >= 12) ? 0 : cls;
        writes = (c == 1) || (c == 3) || (c == 4) || (c == 5);
        if (c == 5 && um) return 6'b000100;
        // p = {ur, uw, sr, sw}
        ok = writes ? (um ? p[2] : p[0]) : (um ? p[3] : p[1]);
        if (ok) return 6'b100000;
        silent = ((c == 2 || c == 3) && lz) || c == 8 || c == 9 || c == 11;
        return {1'b0, !silent, silent, 1'b0, !writes, writes};
    endfunction

    function automatic string req_tag(bit v, bit um, int cls, bit lz, bit [3:0] p);
        logic [5:0] e;
        int c;
        if (!v) return "R8";
        if (cls >= 12) return "R10";
        c = cls;
        if (c == 5 && um) return "R7";
        e = model(v, um, cls, lz, p);
        if (e[5]) begin
            if (c >= 4) return "R3";
            return (e[0] || c == 1 || c == 3) ? "R1" : ((c == 1 || c == 3 || c == 4 || c == 5) ? "R1" : "R2");
        end
        if (e[0]) return "R4";
        return e[3] ? "R6" : "R5";
    endfunction

    task automatic tick(bit r, bit v, bit um, int cls, bit lz, bit [3:0] p);
        logic [5:0] got, exp;
        string      t;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            exp = exp_q.pop_front();
            t   = tag_q.pop_front();
            got = {out_permit, out_dsi, out_nop, out_prog, out_rd_viol, out_wr_viol};
            checks++;
            if (got !== exp) begin
                errors++;
                $display("FAIL %s: got=%b expected=%b", t, got, exp);
            end
        end
        rst       = r;
        req_valid = v;
        user_mode = um;
        op_class  = 4'(cls);
        len_zero  = lz;
        {perm_ur, perm_uw, perm_sr, perm_sw} = p;
        if (r) begin
            exp_q.push_back(6'b0);
            tag_q.push_back("R9");
        end else begin
            exp_q.push_back(model(v, um, cls, lz, p));
            tag_q.push_back(req_tag(v, um, cls, lz, p));
        end
    endtask

    initial begin
        int n = 0;
        // R9: reset clears the outputs even while a request is present
        tick(1'b1, 1'b1, 1'b0, 0, 1'b0, 4'b1111);
        tick(1'b1, 1'b1, 1'b1, 1, 1'b0, 4'b0000);
        tick(1'b1, 1'b0, 1'b0, 0, 1'b0, 4'b0000);
        // Exhaustive sweep (R1..R7, R10) with idle cycles between requests (R8)
        for (int um = 0; um < 2; um++) begin
            for (int cls = 0; cls < 16; cls++) begin
                for (int lz = 0; lz < 2; lz++) begin
                    for (int p = 0; p < 16; p++) begin
                        tick(1'b0, 1'b1, bit'(um), cls, bit'(lz), 4'(p));
                        n++;
                        if (n % 5 == 0) tick(1'b0, 1'b0, 1'b0, 0, 1'b0, 4'b0000);
                    end
                end
            end
        end
        // R9: a reset that arrives mid-stream wipes the verdict
        tick(1'b0, 1'b1, 1'b1, 5, 1'b0, 4'b1111);
        tick(1'b1, 1'b1, 1'b0, 1, 1'b0, 4'b0000);
        tick(1'b0, 1'b1, 1'b0, 3, 1'b1, 4'b0000);
        tick(1'b0, 1'b0, 1'b0, 0, 1'b0, 4'b0000);
        tick(1'b0, 1'b0, 1'b0, 0, 1'b0, 4'b0000);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule